// File: doc/BRIEF.md
# Sync Pin Mode Classifier with Clock-Loss Fallback

This block watches one sync pin of a switching regulator and decides how the regulator is clocked. It recognises three pin states. If the pin sits low, the regulator runs from its internal oscillator with frequency spreading off. If the pin sits high, the regulator runs from its internal oscillator with frequency spreading on. If the pin carries a clock whose period falls inside an allowed band, the regulator locks to that external clock and spreading is forced off. The block counts reference-clock cycles between synchronised rising edges. A period outside the band counts as "no clock". External mode is granted only after a run of consecutive good periods.

When the external clock stops, the fallback depends on the level at which the pin comes to rest. If it rests low, the block returns at once to internal clocking without spreading. If it rests high, spreading is held off for a programmable hold-off time, 256 µs at the default settings, and only then is it turned on. The block also produces a signed triangular modulation code for the oscillator. The code ramps between +AMPL and -AMPL once per modulation period, a 1 kHz rate at the defaults (the oscillator maps the full code swing to about ±3 %). The code is held at zero whenever spreading is off.

Top module: `sync_mode_ctrl`

## Requirements
- R1: During and directly after reset, ext_sync_o, clk_present_o and ss_en_o are 0 and ss_code_o is 0.
- R2: A pin held low with no edges gives ext_sync_o = 0 and ss_en_o = 0.
- R3: A pin held high with no edges, and no external lock lost just before, gives ss_en_o = 1 within 4 reference cycles.
- R4: A rising-edge period counts as in band when its length in reference cycles is within [MIN_PERIOD, MAX_PERIOD] inclusive. clk_present_o is 1 once at least one in-band period has been measured. ext_sync_o becomes 1 after LOCK_PERIODS consecutive in-band periods, and ss_en_o is 0 while it is 1.
- R5: A period shorter than MIN_PERIOD or longer than MAX_PERIOD clears the run of good periods: ext_sync_o and clk_present_o go to 0.
- R6: If no rising edge arrives for MAX_PERIOD reference cycles, clock loss is declared and ext_sync_o goes to 0 within MAX_PERIOD + 8 cycles of the last edge.
- R7: After clock loss with the pin resting low, ss_en_o stays 0.
- R8: After clock loss with the pin resting high, ss_en_o stays 0 for SS_HOLDOFF cycles and then becomes 1 while the pin stays high.
- R9: While ss_en_o is 1, ss_code_o changes by exactly ±1 every SS_STEP_DIV cycles. Its first step is upward from 0. It stays within [-SS_AMPL, +SS_AMPL] and touches both bounds. Successive visits to +SS_AMPL are 4·SS_AMPL·SS_STEP_DIV cycles apart.
- R10: ss_code_o is 0 in every cycle that follows a cycle with ss_en_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock used to measure periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin | input | 1 | Sync pin, asynchronous to clk |
| ext_sync_o | output | 1 | Selects the external clock for the regulator |
| clk_present_o | output | 1 | At least one in-band period seen in the current run |
| ss_en_o | output | 1 | Frequency spreading enabled |
| ss_code_o | output | CODE_W | Signed triangular modulation code |

## Verification
The bench builds the block with a band of 4 to 20 cycles, a lock run of 3 periods, a 50-cycle hold-off, an amplitude of 3 and a step divider of 2. With these values a full modulation period takes 24 cycles, and a lock, a loss and the complete hold-off each fit into about a hundred cycles. That makes it practical to test the exact band edges (3, 4, 20 and 21 cycles), to break a lock with a single short period, and to run many random bursts with a random fallback level within the run budget.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

  // A measured period (in reference cycles) is usable when inside the band.
  function automatic logic period_in_band(input int elapsed, input int lo, input int hi);
    return (elapsed >= lo) && (elapsed <= hi);
  endfunction

  // One step of the triangle in the current direction.
  function automatic int tri_next(input int code, input logic up);
    return up ? code + 1 : code - 1;
  endfunction

  // Direction after a step: turn around on reaching either bound.
  function automatic logic tri_dir(input int next_code, input logic up, input int ampl);
    if (next_code >= ampl)  return 1'b0;
    if (next_code <= -ampl) return 1'b1;
    return up;
  endfunction

endpackage

// File: rtl/sync_edge_meter.sv
module sync_edge_meter #(
  parameter int MAX_PERIOD = 167,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  output logic             level_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] since_o,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_PERIOD);

  logic s0_q, s1_q, s2_q;
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s0_q <= pin;
      s1_q <= s0_q;
      s2_q <= s1_q;
    end
  end

  assign rise_o    = s1_q & ~s2_q;
  assign level_o   = s2_q;
  assign timeout_o = (since_q == CNT_SAT);
  assign since_o   = since_q;

  // Cycles since the last rising edge, saturating at the loss limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_q <= CNT_SAT;
    else if (rise_o)          since_q <= '0;
    else if (!timeout_o)      since_q <= since_q + 1'b1;
  end

  p_since_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    since_q <= CNT_SAT);

  p_since_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (since_q == '0));

endmodule

// File: rtl/sync_lock_ctrl.sv
module sync_lock_ctrl
  import sync_mode_pkg::*;
#(
  parameter int MIN_PERIOD   = 22,
  parameter int MAX_PERIOD   = 167,
  parameter int LOCK_PERIODS = 4,
  parameter int SS_HOLDOFF   = 12800,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             level,
  input  logic [CNT_W-1:0] since,
  input  logic             timeout,
  output logic             ext_sync_o,
  output logic             clk_present_o,
  output logic             ss_en_o
);

  localparam int LK_W  = $clog2(LOCK_PERIODS + 1);
  localparam int DLY_W = $clog2(SS_HOLDOFF + 1);
  localparam logic [LK_W-1:0]  LK_FULL  = LK_W'(LOCK_PERIODS);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SS_HOLDOFF - 1);

  logic [LK_W-1:0]  good_q;
  logic [DLY_W-1:0] dly_q;
  logic             armed_q;
  logic             in_band;

  assign in_band = period_in_band(int'(since) + 1, MIN_PERIOD, MAX_PERIOD);

  // Run of consecutive good periods.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           good_q <= '0;
    else if (rise)        good_q <= !in_band ? '0 :
                                    (good_q == LK_FULL) ? good_q : good_q + 1'b1;
    else if (timeout)     good_q <= '0;
  end

  assign ext_sync_o    = (good_q == LK_FULL);
  assign clk_present_o = (good_q != '0);

  // Hold-off of spreading after a lock is lost with the pin resting high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else if (ext_sync_o) begin
      armed_q <= 1'b1;
      dly_q   <= '0;
    end else if (armed_q) begin
      if (!level || dly_q >= DLY_LAST) armed_q <= 1'b0;
      else                             dly_q   <= dly_q + 1'b1;
    end
  end

  assign ss_en_o = ~ext_sync_o & level & ~armed_q;

  p_lock_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_sync_o) |-> $past(rise));

  p_bad_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !in_band) |=> (!ext_sync_o && !clk_present_o));

  p_loss_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !ext_sync_o);

  p_high_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ext_sync_o) && level) |-> !ss_en_o);

endmodule

// File: rtl/ss_tri_gen.sv
module ss_tri_gen
  import sync_mode_pkg::*;
#(
  parameter int AMPL     = 31,
  parameter int STEP_DIV = 403,
  parameter int CODE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  output logic signed [CODE_W-1:0] code_o
);

  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);

  logic [DIV_W-1:0]         div_q;
  logic                     up_q;
  logic signed [CODE_W-1:0] code_q;
  logic                     step_tick;
  int                       nxt_code;

  assign step_tick = en && (div_q == DIV_LAST);

  always_comb nxt_code = tri_next(int'(code_q), up_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      up_q   <= 1'b1;
      code_q <= '0;
    end else if (!en) begin
      div_q  <= '0;
      up_q   <= 1'b1;
      code_q <= '0;
    end else begin
      div_q <= step_tick ? '0 : div_q + 1'b1;
      if (step_tick) begin
        code_q <= CODE_W'(nxt_code);
        up_q   <= tri_dir(nxt_code, up_q, AMPL);
      end
    end
  end

  assign code_o = code_q;

  p_code_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_q) <= AMPL) && (int'(code_q) >= -AMPL));

  p_code_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ((code_q == $past(code_q)) ||
                           (int'(code_q) == int'($past(code_q)) + 1) ||
                           (int'(code_q) == int'($past(code_q)) - 1)));

  p_code_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code_q == '0));

endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl #(
  parameter int MIN_PERIOD   = 22,
  parameter int MAX_PERIOD   = 167,
  parameter int LOCK_PERIODS = 4,
  parameter int SS_HOLDOFF   = 12800,
  parameter int SS_AMPL      = 31,
  parameter int SS_STEP_DIV  = 403,
  parameter int CODE_W       = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_pin,
  output logic                     ext_sync_o,
  output logic                     clk_present_o,
  output logic                     ss_en_o,
  output logic signed [CODE_W-1:0] ss_code_o
);

  localparam int CNT_W = $clog2(MAX_PERIOD + 1);

  logic             level;
  logic             rise;
  logic             timeout;
  logic [CNT_W-1:0] since;

  sync_edge_meter #(
    .MAX_PERIOD (MAX_PERIOD),
    .CNT_W      (CNT_W)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (sync_pin),
    .level_o   (level),
    .rise_o    (rise),
    .since_o   (since),
    .timeout_o (timeout)
  );

  sync_lock_ctrl #(
    .MIN_PERIOD   (MIN_PERIOD),
    .MAX_PERIOD   (MAX_PERIOD),
    .LOCK_PERIODS (LOCK_PERIODS),
    .SS_HOLDOFF   (SS_HOLDOFF),
    .CNT_W        (CNT_W)
  ) u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise          (rise),
    .level         (level),
    .since         (since),
    .timeout       (timeout),
    .ext_sync_o    (ext_sync_o),
    .clk_present_o (clk_present_o),
    .ss_en_o       (ss_en_o)
  );

  ss_tri_gen #(
    .AMPL     (SS_AMPL),
    .STEP_DIV (SS_STEP_DIV),
    .CODE_W   (CODE_W)
  ) u_tri (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ss_en_o),
    .code_o (ss_code_o)
  );

  p_no_spread_in_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_o |=> (ss_code_o == '0));

endmodule

// File: tb/sync_mode_ctrl_tb.sv
module sync_mode_ctrl_tb;

  localparam int MINP  = 4;
  localparam int MAXP  = 20;
  localparam int LOCKN = 3;
  localparam int HOLD  = 50;
  localparam int AMP   = 3;
  localparam int SDIV  = 2;
  localparam int CW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_pin = 1'b0;
  logic ext_sync, clk_present, ss_en;
  logic signed [CW-1:0] ss_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sync_mode_ctrl #(
    .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP), .LOCK_PERIODS(LOCKN),
    .SS_HOLDOFF(HOLD), .SS_AMPL(AMP), .SS_STEP_DIV(SDIV), .CODE_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin),
    .ext_sync_o(ext_sync), .clk_present_o(clk_present),
    .ss_en_o(ss_en), .ss_code_o(ss_code)
  );

  function automatic bit exp_in_band(input int p);
    return (p >= MINP) && (p <= MAXP);
  endfunction

  function automatic int exp_tri_period();
    return 4 * AMP * SDIV;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // k rising edges spaced p cycles; returns at the end of the last low phase
  task automatic burst(input int p, input int k);
    for (int i = 0; i < k; i++) begin
      sync_pin = 1'b1;
      cyc(p / 2);
      sync_pin = 1'b0;
      cyc(p - p / 2);
    end
  endtask

  task automatic observe_triangle();
    int prev, maxv, minv, first_nz, bad, last_top, per, tops;
    prev = 0; maxv = 0; minv = 0; first_nz = 0; bad = 0; last_top = -1; per = 0; tops = 0;
    for (int t = 0; t < 80; t++) begin
      @(negedge clk);
      if (ss_code != prev) begin
        if (int'(ss_code) - prev != 1 && int'(ss_code) - prev != -1) bad++;
        if (first_nz == 0) first_nz = int'(ss_code);
        if (int'(ss_code) == AMP) begin
          if (last_top >= 0) begin per = t - last_top; tops++; end
          last_top = t;
        end
      end
      if (int'(ss_code) > maxv) maxv = int'(ss_code);
      if (int'(ss_code) < minv) minv = int'(ss_code);
      prev = int'(ss_code);
    end
    chk("R9 step size", bad, 0);
    chk("R9 first step up", first_nz, 1);
    chk("R9 upper bound", maxv, AMP);
    chk("R9 lower bound", minv, -AMP);
    chk("R9 modulation period", per, exp_tri_period());
    chk("R9 top visits", (tops >= 1) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed, p, k, lvl;
    seed = $urandom(32'd2024);

    // R1 reset state
    cyc(3);
    chk("R1 ext in reset", ext_sync, 0);
    chk("R1 ss in reset", ss_en, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 ext after reset", ext_sync, 0);
    chk("R1 present after reset", clk_present, 0);
    chk("R1 ss after reset", ss_en, 0);
    chk("R1 code after reset", int'(ss_code), 0);

    // R2 static low
    cyc(40);
    chk("R2 ext static low", ext_sync, 0);
    chk("R2 ss static low", ss_en, 0);
    chk("R10 code static low", int'(ss_code), 0);

    // R3 static high, then R9 triangle
    sync_pin = 1'b1;
    cyc(4);
    chk("R3 ss static high", ss_en, 1);
    chk("R3 ext static high", ext_sync, 0);
    observe_triangle();

    // R10 spreading off returns code to zero
    sync_pin = 1'b0;
    cyc(4);
    chk("R10 ss off", ss_en, 0);
    chk("R10 code zero", int'(ss_code), 0);
    cyc(MAXP + 8);

    // R4 one good period: present but not locked
    burst(8, 2);
    chk("R4 present after one period", clk_present, 1);
    chk("R4 no lock after one period", ext_sync, 0);
    cyc(MAXP + 8);

    // R4 / R5 band boundaries
    burst(MINP, LOCKN + 1);
    chk("R4 lock at MIN period", ext_sync, exp_in_band(MINP) ? 1 : 0);
    cyc(MAXP + 8);
    burst(MAXP, LOCKN + 1);
    chk("R4 lock at MAX period", ext_sync, exp_in_band(MAXP) ? 1 : 0);
    chk("R4 ss off in ext", ss_en, 0);
    cyc(MAXP + 8);
    burst(MINP - 1, LOCKN + 3);
    chk("R5 no lock below MIN", ext_sync, exp_in_band(MINP - 1) ? 1 : 0);
    chk("R5 no presence below MIN", clk_present, 0);
    cyc(MAXP + 8);
    burst(MAXP + 1, LOCKN + 2);
    chk("R5 no lock above MAX", ext_sync, exp_in_band(MAXP + 1) ? 1 : 0);
    chk("R5 no presence above MAX", clk_present, 0);
    cyc(MAXP + 8);

    // R5 one short period breaks an established lock
    burst(10, LOCKN + 2);
    chk("R4 lock before break", ext_sync, 1);
    burst(3, 2);
    chk("R5 lock broken by short period", ext_sync, 0);
    chk("R5 presence cleared", clk_present, 0);
    cyc(MAXP + 8);

    // Random bursts with random fallback level
    for (int it = 0; it < 12; it++) begin
      p   = MINP + int'($urandom % (MAXP - MINP + 1));
      k   = LOCKN + 1 + int'($urandom % 3);
      lvl = int'($urandom % 2);
      burst(p, k);
      chk("R4 random lock", ext_sync, 1);
      chk("R4 random present", clk_present, 1);
      chk("R4 random ss off", ss_en, 0);
      chk("R10 random code zero", int'(ss_code), 0);
      if (lvl == 1) begin
        sync_pin = 1'b1;
        cyc(MAXP + 8);
        chk("R6 loss high", ext_sync, 0);
        chk("R8 holdoff early", ss_en, 0);
        cyc(25);
        chk("R8 holdoff late", ss_en, 0);
        cyc(45);
        chk("R8 spread after holdoff", ss_en, 1);
        sync_pin = 1'b0;
      end else begin
        cyc(MAXP + 8);
        chk("R6 loss low", ext_sync, 0);
        chk("R7 no spread low", ss_en, 0);
        cyc(70);
        chk("R7 still no spread", ss_en, 0);
        chk("R10 code zero low", int'(ss_code), 0);
      end
      cyc(MAXP + 8);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule